// File: doc/BRIEF.md
# Paged Flash Address Translator

This block turns a 16-bit processor address and an 8-bit page register into a linear address inside a 256 kB flash array. The array is made of 16 kB pages. The processor's 64 kB address space is split into four 16 kB quarters. The lowest quarter never belongs to flash. The second quarter is tied to page 0x3E, and the top quarter is tied to page 0x3F. The third quarter is a movable window that shows whichever page the page register names.

The translator is purely combinational. A bus front end presents an address, the page register value and an access strobe. It receives back four things in the same cycle:
- a hit flag saying that flash should answer;
- a bad-page flag for window accesses whose page lies outside the fitted array;
- the effective page number, for debug;
- two forms of the address: a full image address (page × 0x4000 + address − 0x8000) and the 18-bit array address measured from the base of page 0x30.

Top module: `paged_flash_xlate`

## Requirements
- R1: For a CPU address in 0x0000–0x3FFF, the hit flag, the bad-page flag, the page output, the image address and the array address are all zero, whatever the strobe and the page register hold.
- R2: For a CPU address in 0x4000–0x7FFF, the page output is 0x3E and the image address is 0x3E × 0x4000 + (address − 0x4000).
- R3: For a CPU address in 0xC000–0xFFFF, the page output is 0x3F and the image address is 0x3F × 0x4000 + (address − 0xC000).
- R4: For a CPU address in 0x8000–0xBFFF, the page output equals the page register.
- R5: For a window address, the 22-bit image address equals page × 0x4000 + address − 0x8000. For example, page 0x20 with address 0xA003 gives 0x82003.
- R6: The 18-bit array address equals the image address minus 0xC0000, taken modulo 2^18. Page 0x30 at window address 0x8000 gives array address 0.
- R7: Only pages 0x30–0x3F are fitted. A strobed window access with any other page raises the bad-page flag and holds the hit flag low.
- R8: With the strobe low, the hit and bad-page flags are both low. The page output and both addresses are still produced.
- R9: A strobed access outside the low quarter with a fitted page raises the hit flag. Pages 0x3E and 0x3F reached through the window give the same array address as the matching fixed quarter at the same offset.
- R10: Outside the window quarter, the page register has no effect on any output.
- R11: Every output is a function of the present inputs only and settles within the same clock period as the input change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpuAddr | input | 16 | Processor address |
| pageReg | input | 8 | Current page register value used by the window |
| accStb | input | 1 | Access strobe qualifying the flags |
| imageAddr | output | 22 | Full image address, page × 0x4000 + offset |
| flashAddr | output | 18 | Array address relative to the base of page 0x30 |
| pageOut | output | 8 | Effective page number (debug) |
| flashHit | output | 1 | Flash answers this access |
| pageBad | output | 1 | Strobed window access to an unfitted page |

## Verification
The embedded assertions watch several rules at every input change:
- the low quarter never produces a hit;
- a low strobe never produces a flag;
- the array address always keeps the processor's 14 offset bits;
- a hit always falls inside the fitted page range;
- the fixed quarters always report their fixed page;
- at most one quarter is selected at a time.

Other properties are arithmetic and only the bench's reference model can confirm them: the exact image value, the wrap that produces the array address, the equivalence between window and fixed views of pages 0x3E and 0x3F, and the page register having no effect outside the window. The bench drives directed boundary addresses and pages, plus a per-clock random sweep.

// File: rtl/pft_pkg.sv
package pft_pkg;

  // Strobes handed from the region decoder to the address datapath.
  typedef struct packed {
    logic selLow;
    logic selFixLo;
    logic selWin;
    logic selFixHi;
    logic hit;
    logic pageBad;
  } xlateCtl_t;

  // Quarter codes given by the two top address bits.
  typedef enum logic [1:0] {
    QTR_LOW   = 2'b00,
    QTR_FIXLO = 2'b01,
    QTR_WIN   = 2'b10,
    QTR_FIXHI = 2'b11
  } quarter_e;

endpackage

// File: rtl/pft_ctrl.sv
module pft_ctrl
  import pft_pkg::*;
#(
  parameter int PAGE_W     = 8,
  parameter int FIRST_PAGE = 'h30,
  parameter int NUM_PAGES  = 16
) (
  input  logic [1:0]        regionBits,
  input  logic [PAGE_W-1:0] pageReg,
  input  logic              accStb,
  output xlateCtl_t         ctl
);

  localparam int CMP_W = PAGE_W + 1;
  localparam logic [CMP_W-1:0] LOW_BOUND = CMP_W'(FIRST_PAGE);
  localparam logic [CMP_W-1:0] TOP_BOUND = CMP_W'(FIRST_PAGE + NUM_PAGES);

  quarter_e   quarter;
  logic       pageOk;
  logic [CMP_W-1:0] pageWide;

  assign quarter  = quarter_e'(regionBits);
  assign pageWide = {1'b0, pageReg};
  assign pageOk   = (pageWide >= LOW_BOUND) && (pageWide < TOP_BOUND);

  always_comb begin
    ctl = '0;
    unique case (quarter)
      QTR_LOW:   ctl.selLow   = 1'b1;
      QTR_FIXLO: ctl.selFixLo = 1'b1;
      QTR_WIN:   ctl.selWin   = 1'b1;
      QTR_FIXHI: ctl.selFixHi = 1'b1;
      default:   ctl.selLow   = 1'b1;
    endcase
    ctl.hit     = accStb & ~ctl.selLow & (~ctl.selWin | pageOk);
    ctl.pageBad = accStb & ctl.selWin & ~pageOk;
  end

  // R11: the decode yields exactly one quarter at a time
  always_comb begin
    assert_one_quarter_R11: assert ($onehot0({ctl.selLow, ctl.selFixLo, ctl.selWin, ctl.selFixHi}))
      else $error("more than one quarter selected");
  end

endmodule

// File: rtl/pft_dp.sv
module pft_dp
  import pft_pkg::*;
#(
  parameter int PAGE_W      = 8,
  parameter int OFF_W       = 14,
  parameter int LIN_W       = 18,
  parameter int FIX_LO_PAGE = 'h3E,
  parameter int FIX_HI_PAGE = 'h3F
) (
  input  xlateCtl_t           ctl,
  input  logic [PAGE_W-1:0]   pageReg,
  input  logic [OFF_W-1:0]    cpuOff,
  output logic [PAGE_W-1:0]   pageOut,
  output logic [PAGE_W+OFF_W-1:0] imageAddr,
  output logic [LIN_W-1:0]    flashAddr
);

  localparam int IMG_W = PAGE_W + OFF_W;
  localparam logic [PAGE_W-1:0] FIX_LO_V = PAGE_W'(FIX_LO_PAGE);
  localparam logic [PAGE_W-1:0] FIX_HI_V = PAGE_W'(FIX_HI_PAGE);

  logic [PAGE_W-1:0] pageSel;
  logic [IMG_W-1:0]  imageNext;

  always_comb begin
    pageSel = '0;
    if (ctl.selFixLo)      pageSel = FIX_LO_V;
    else if (ctl.selFixHi) pageSel = FIX_HI_V;
    else if (ctl.selWin)   pageSel = pageReg;
  end

  // Every flash quarter uses its own 14-bit offset, so the image is the
  // page number concatenated above the offset.
  assign imageNext = ctl.selLow ? '0 : {pageSel, cpuOff};
  assign imageAddr = imageNext;
  assign pageOut   = pageSel;

  generate
    if (LIN_W <= IMG_W) begin : g_trunc
      assign flashAddr = imageNext[LIN_W-1:0];
    end else begin : g_extend
      assign flashAddr = {{(LIN_W-IMG_W){1'b0}}, imageNext};
    end
  endgenerate

  // R2: the lower fixed quarter always reports its fixed page
  always_comb begin
    if (ctl.selFixLo)
      assert_fixlo_page_R2: assert (pageOut == FIX_LO_V)
        else $error("fixed low page wrong");
  end

  // R3: the upper fixed quarter always reports its fixed page
  always_comb begin
    if (ctl.selFixHi)
      assert_fixhi_page_R3: assert (pageOut == FIX_HI_V)
        else $error("fixed high page wrong");
  end

endmodule

// File: rtl/paged_flash_xlate.sv
module paged_flash_xlate
  import pft_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int PAGE_W      = 8,
  parameter int OFF_W       = 14,
  parameter int FIRST_PAGE  = 'h30,
  parameter int NUM_PAGES   = 16,
  parameter int FIX_LO_PAGE = 'h3E,
  parameter int FIX_HI_PAGE = 'h3F
) (
  input  logic [ADDR_W-1:0]       cpuAddr,
  input  logic [PAGE_W-1:0]       pageReg,
  input  logic                    accStb,
  output logic [PAGE_W+OFF_W-1:0] imageAddr,
  output logic [$clog2(NUM_PAGES)+OFF_W-1:0] flashAddr,
  output logic [PAGE_W-1:0]       pageOut,
  output logic                    flashHit,
  output logic                    pageBad
);

  localparam int LIN_W = $clog2(NUM_PAGES) + OFF_W;
  localparam int IMG_W = PAGE_W + OFF_W;
  localparam logic [IMG_W-1:0] FIRST_IMG = IMG_W'(FIRST_PAGE) << OFF_W;
  localparam logic [IMG_W-1:0] END_IMG   = IMG_W'(FIRST_PAGE + NUM_PAGES) << OFF_W;

  xlateCtl_t ctl;

  pft_ctrl #(
    .PAGE_W    (PAGE_W),
    .FIRST_PAGE(FIRST_PAGE),
    .NUM_PAGES (NUM_PAGES)
  ) u_ctrl (
    .regionBits(cpuAddr[ADDR_W-1 -: 2]),
    .pageReg   (pageReg),
    .accStb    (accStb),
    .ctl       (ctl)
  );

  pft_dp #(
    .PAGE_W     (PAGE_W),
    .OFF_W      (OFF_W),
    .LIN_W      (LIN_W),
    .FIX_LO_PAGE(FIX_LO_PAGE),
    .FIX_HI_PAGE(FIX_HI_PAGE)
  ) u_dp (
    .ctl      (ctl),
    .pageReg  (pageReg),
    .cpuOff   (cpuAddr[OFF_W-1:0]),
    .pageOut  (pageOut),
    .imageAddr(imageAddr),
    .flashAddr(flashAddr)
  );

  assign flashHit = ctl.hit;
  assign pageBad  = ctl.pageBad;

  // R1: the low quarter never hits flash
  always_comb begin
    if (cpuAddr[ADDR_W-1 -: 2] == 2'b00)
      assert_low_no_hit_R1: assert (!flashHit && imageAddr == '0)
        else $error("low quarter produced flash output");
  end

  // R8: no flag without a strobe
  always_comb begin
    if (!accStb)
      assert_no_flag_idle_R8: assert (!flashHit && !pageBad)
        else $error("flag raised without strobe");
  end

  // R6: the array address keeps the processor's offset bits
  always_comb begin
    if (cpuAddr[ADDR_W-1 -: 2] != 2'b00)
      assert_offset_kept_R6: assert (flashAddr[OFF_W-1:0] == cpuAddr[OFF_W-1:0])
        else $error("offset bits altered");
  end

  // R7: a hit always lands inside the fitted page range
  always_comb begin
    if (flashHit)
      assert_hit_in_range_R7: assert (imageAddr >= FIRST_IMG && imageAddr < END_IMG && !pageBad)
        else $error("hit outside fitted pages");
  end

endmodule

// File: tb/paged_flash_xlate_bench.sv
module paged_flash_xlate_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  pageReg = '0;
  logic        accStb  = 1'b0;
  logic [21:0] imageAddr;
  logic [17:0] flashAddr;
  logic [7:0]  pageOut;
  logic        flashHit;
  logic        pageBad;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  paged_flash_xlate u_paged_flash_xlate (
    .cpuAddr  (cpuAddr),
    .pageReg  (pageReg),
    .accStb   (accStb),
    .imageAddr(imageAddr),
    .flashAddr(flashAddr),
    .pageOut  (pageOut),
    .flashHit (flashHit),
    .pageBad  (pageBad)
  );

  // Behavioural reference built from the requirement text.
  task automatic refModel(input int a, input int p, input bit s,
                          output int eImg, output int eLin, output int ePage,
                          output bit eHit, output bit eBad);
    bit fitted;
    if (a < 'h4000) begin
      eImg = 0; eLin = 0; ePage = 0; eHit = 0; eBad = 0;
    end else begin
      if (a < 'h8000) begin
        ePage = 'h3E; eImg = ePage * 'h4000 + (a - 'h4000);
      end else if (a < 'hC000) begin
        ePage = p;    eImg = ePage * 'h4000 + a - 'h8000;
      end else begin
        ePage = 'h3F; eImg = ePage * 'h4000 + (a - 'hC000);
      end
      eLin   = (eImg - 'hC0000) & 'h3FFFF;
      fitted = (ePage >= 'h30) && (ePage <= 'h3F);
      eHit   = s && fitted;
      eBad   = s && (a >= 'h8000) && (a < 'hC000) && !fitted;
    end
  endtask

  task automatic applyCheck(input int a, input int p, input bit s, input string tag);
    int eImg, eLin, ePage;
    bit eHit, eBad;
    @(negedge clk);
    cpuAddr = a[15:0];
    pageReg = p[7:0];
    accStb  = s;
    #1;
    refModel(a, p, s, eImg, eLin, ePage, eHit, eBad);
    total++;
    if (int'(imageAddr) != eImg || int'(flashAddr) != eLin || int'(pageOut) != ePage ||
        flashHit != eHit || pageBad != eBad) begin
      bad++;
      $display("FAIL %s a=%h p=%h s=%0b: img=%h lin=%h pg=%h hit=%0b bad=%0b exp img=%h lin=%h pg=%h hit=%0b bad=%0b",
               tag, a, p, s, imageAddr, flashAddr, pageOut, flashHit, pageBad,
               eImg, eLin, ePage, eHit, eBad);
    end
  endtask

  task automatic checkValue(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int linA;
    repeat (3) @(posedge clk);
    #2;
    // Idle state while bench reset is held: all inputs zero (R1, R8)
    checkValue(int'(flashHit), 0, "R1 idle hit");
    checkValue(int'(pageBad), 0, "R8 idle bad");
    rst = 1'b0;

    applyCheck('h0000, 'h35, 1, "R1 low bottom");
    applyCheck('h3FFF, 'h3C, 1, "R1 low top");
    applyCheck('h4000, 'h00, 1, "R2 fixlo start");
    applyCheck('h7FFF, 'h30, 1, "R2 fixlo end");
    applyCheck('hC000, 'h31, 1, "R3 fixhi start");
    applyCheck('hFFFF, 'hFF, 1, "R3 fixhi end");
    applyCheck('h9234, 'h37, 1, "R4 window page");
    applyCheck('hA003, 'h20, 1, "R5 example");
    checkValue(int'(imageAddr), 'h82003, "R5 image value");
    applyCheck('h8000, 'h30, 1, "R6 array base");
    checkValue(int'(flashAddr), 0, "R6 zero");
    applyCheck('hBFFF, 'h3F, 1, "R6 array top");
    applyCheck('h8000, 'h2F, 1, "R7 below range");
    applyCheck('h8000, 'h40, 1, "R7 above range");
    applyCheck('h8123, 'h00, 1, "R7 page zero");
    applyCheck('h8123, 'h40, 0, "R8 bad page no strobe");
    applyCheck('h5555, 'h3E, 0, "R8 fixlo no strobe");
    applyCheck('hA5A5, 'h3E, 1, "R9 window 3E");
    linA = int'(flashAddr);
    applyCheck('h65A5, 'h11, 1, "R9 fixlo same offset");
    checkValue(int'(flashAddr), linA, "R9 alias 3E");
    applyCheck('h9ABC, 'h3F, 1, "R9 window 3F");
    linA = int'(flashAddr);
    applyCheck('hDABC, 'h22, 1, "R9 fixhi same offset");
    checkValue(int'(flashAddr), linA, "R9 alias 3F");
    applyCheck('h4321, 'h00, 1, "R10 fixlo page 00");
    applyCheck('h4321, 'hC7, 1, "R10 fixlo page C7");
    applyCheck('hE000, 'h12, 1, "R10 fixhi page 12");
    applyCheck('h1000, 'h3A, 1, "R10 low page 3A");

    // Per-clock random sweep against the model (R11)
    for (int i = 0; i < 3000; i++) begin
      int a, p;
      a = int'($urandom_range(0, 'hFFFF));
      p = (i % 3 == 0) ? int'($urandom_range(0, 255)) : int'($urandom_range('h2E, 'h41));
      applyCheck(a, p, bit'($urandom_range(0, 1)), "R11 sweep");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule